// File: doc/BRIEF.md
# Multiplicative Convergence Divider

The block divides one positive fixed-point fraction by another with no subtraction step. The divisor is shifted left until its top bit is set. The dividend is shifted left by the same count, so the ratio does not change. A small table, addressed by the divisor bits just below its leading one, supplies a first scaling factor that is close to the reciprocal of the divisor. From then on, both numerator and denominator are multiplied by a common factor each cycle. Each new factor is two minus the current denominator. The denominator approaches one quadratically, and the numerator approaches the quotient.

Software or a sequencer drives the two operands and pulses `start`. A few cycles later the block raises `done` for one cycle and presents the quotient in an unsigned format with two integer bits and thirty fraction bits. The quotient stays on the output until the next result. The caller must supply a nonzero divisor and a dividend smaller than twice the divisor.

Top module: `cdiv_top`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `quotient` is 0 until the first result.
- R2: For nonzero `divisor` and `dividend` < 2·`divisor` (both unsigned 16-bit fractions, value = code/2^16), `quotient` is within 16 counts of floor(`dividend`·2^30 / `divisor`), in Q2.30.
- R3: A zero dividend yields a quotient of exactly 0.
- R4: The result meets R2 for every position of the divisor's leading one, from bit 15 down to bit 0.
- R5: `done` is high for exactly one cycle per accepted operation and never two cycles in a row.
- R6: `done` rises between 1 and 5 rising edges after the edge that accepted `start`. The limit is a cap of 5 multiply steps.
- R7: A `start` seen while an operation is in progress is ignored. It produces no extra result and does not alter the running one.
- R8: `quotient` holds its value in every cycle in which `done` is low.
- R9: A reset in the middle of an operation aborts it. No `done` follows, and `quotient` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | 16 | Numerator, unsigned fraction Q0.16 |
| divisor | input | 16 | Denominator, unsigned fraction Q0.16, nonzero |
| quotient | output | 32 | Result, unsigned Q2.30 |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench sweeps the divisor's leading one across all sixteen positions. A wrong shift count, or a dividend that is not shifted along with the divisor, scales the quotient by a power of two. It drives quotients near 2 and near 1, and a zero dividend. A truncation slice taken at the wrong offset, or an overflowing product, shows up there as a large error, and a leaky datapath gives a nonzero result for zero. A second `start` during a busy period would make a faulty controller reload its operands or emit a spurious result. A mid-operation reset would let a broken design deliver a stale strobe. The bench also measures latency, so a convergence test that never fires is caught by the iteration cap's bound.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    localparam int DW       = 32;   // working word, Q2.30
    localparam int FRAC     = 30;
    localparam int SEED_IDX = 4;    // divisor bits used to address the seed table
    localparam int SEED_FB  = 8;    // seed fraction bits, one integer bit
    localparam int SEED_N   = 1 << SEED_IDX;

    typedef logic [DW-1:0] fix_t;

    localparam fix_t ONE = fix_t'(1) << FRAC;
    localparam fix_t TWO = fix_t'(2) << FRAC;

    typedef enum logic {ST_IDLE, ST_RUN} state_e;

    typedef struct packed {
        fix_t num;
        fix_t den;
    } pair_t;

    // Reciprocal of the midpoint of table slot k, rounded to 1.SEED_FB bits.
    function automatic logic [SEED_FB:0] seed_calc(int k);
        int d;
        int n;
        d = (1 << (SEED_IDX + 1)) + 2 * k + 1;
        n = 1 << (SEED_IDX + 2 + SEED_FB);
        return (SEED_FB + 1)'((n + d / 2) / d);
    endfunction
endpackage

// File: rtl/cdiv_norm.sv
module cdiv_norm
    import cdiv_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0]     num_in,
    input  logic [IN_W-1:0]     den_in,
    output fix_t                num_n,
    output fix_t                den_n,
    output logic [SEED_IDX-1:0] idx
);
    localparam int SH_W = $clog2(IN_W);
    localparam int PAD  = FRAC - IN_W;

    logic [SH_W-1:0] sh;
    logic [IN_W-1:0] den_sh;

    always_comb begin
        sh = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (den_in[i]) sh = SH_W'(IN_W - 1 - i);
        end
        den_sh = den_in << sh;
        den_n  = fix_t'(den_sh) << PAD;
        num_n  = fix_t'(num_in) << (PAD + int'(sh));
        idx    = den_sh[IN_W-2 -: SEED_IDX];
    end

    always_comb begin
        if (den_in != '0) begin
            a_r4_leading_one: assert (den_sh[IN_W-1]);
        end
    end
endmodule

// File: rtl/cdiv_seed.sv
module cdiv_seed
    import cdiv_pkg::*;
(
    input  logic [SEED_IDX-1:0] idx,
    output fix_t                f0
);
    logic [SEED_FB:0] rom [SEED_N];

    for (genvar g = 0; g < SEED_N; g++) begin : g_rom
        assign rom[g] = seed_calc(g);
    end

    assign f0 = fix_t'(rom[idx]) << (FRAC - SEED_FB);
endmodule

// File: rtl/cdiv_mulpair.sv
module cdiv_mulpair
    import cdiv_pkg::*;
(
    input  pair_t cur,
    input  fix_t  f,
    output pair_t nxt
);
    fix_t ops [2];
    fix_t res [2];

    assign ops[0] = cur.num;
    assign ops[1] = cur.den;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [2*DW-1:0] p;
        assign p      = {{DW{1'b0}}, ops[g]} * {{DW{1'b0}}, f};
        assign res[g] = fix_t'(p >> FRAC);
        always_comb begin
            a_r2_no_overflow: assert (p[2*DW-1 -: 2] == 2'b00);
        end
    end

    assign nxt.num = res[0];
    assign nxt.den = res[1];
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
    import cdiv_pkg::*;
#(
    parameter int IN_W     = 16,
    parameter int ITER_MAX = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [IN_W-1:0] dividend,
    input  logic [IN_W-1:0] divisor,
    output logic [DW-1:0]   quotient,
    output logic            done
);
    localparam int SW = $clog2(ITER_MAX + 1);

    state_e              state;
    pair_t               cur, nxt, init;
    fix_t                f_r, f0;
    logic [SW-1:0]       steps;
    logic [SEED_IDX-1:0] idx;
    logic                converged;

    cdiv_norm #(.IN_W(IN_W)) u_norm (
        .num_in (dividend),
        .den_in (divisor),
        .num_n  (init.num),
        .den_n  (init.den),
        .idx    (idx)
    );

    cdiv_seed u_seed (.idx(idx), .f0(f0));

    cdiv_mulpair u_mul (.cur(cur), .f(f_r), .nxt(nxt));

    assign converged = (nxt.den >= ONE - fix_t'(1)) && (nxt.den <= ONE + fix_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur      <= '0;
            f_r      <= '0;
            steps    <= '0;
            quotient <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur   <= init;
                        f_r   <= f0;
                        steps <= '0;
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cur   <= nxt;
                    f_r   <= TWO - nxt.den;
                    steps <= steps + SW'(1);
                    if (converged || steps == SW'(ITER_MAX - 1)) begin
                        quotient <= nxt.num;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_step_cap: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (steps < SW'(ITER_MAX)));

    a_r8_quotient_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(quotient));

    a_r3_zero_stays: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && cur.num == '0) |=> (cur.num == '0));

    a_r7_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && start && !converged && steps != SW'(ITER_MAX - 1))
        |=> (state == ST_RUN));
endmodule

// File: tb/cdiv_top_tb_top.sv
module cdiv_top_tb_top;
    localparam int  TOL    = 16;
    localparam int  MAXLAT = 5;

    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        string       req;
        int          t0;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = 16'h8000;
    logic [31:0] quotient;
    logic        done;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    n_done = 0;
    bit    prev_done = 1'b0;
    bit    finished = 1'b0;
    logic [31:0] last_q = '0;
    item_t sb [$];
    logic [31:0] rs = 32'h1234_5677;

    cdiv_top dut_i (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .quotient(quotient), .done(done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            prev_done = 1'b0;
        end else begin
            if (done) begin
                n_done++;
                check(!prev_done, "R5", "done high two cycles", 1, 0);
                if (sb.size() == 0) begin
                    check(1'b0, "R7/R9", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    longint exp, act, diff;
                    int lat;
                    it   = sb.pop_front();
                    exp  = (longint'(it.a) << 30) / longint'(it.b);
                    act  = longint'(quotient);
                    diff = act - exp;
                    if (diff < 0) diff = -diff;
                    if (it.a == 0)
                        check(act == 0, "R3", "zero dividend quotient", act, 0);
                    else
                        check(diff <= TOL, it.req, "quotient", act, exp);
                    lat = cyc - it.t0 - 1;
                    check(lat >= 1 && lat <= MAXLAT, "R6", "latency edges", lat, MAXLAT);
                    last_q = quotient;
                end
            end
            prev_done = done;
        end
    end

    task automatic wait_empty();
        for (int k = 0; k < 50 && sb.size() != 0; k++) begin
            @(negedge clk);
            #1;
        end
        check(sb.size() == 0, "R6", "result never arrived", sb.size(), 0);
    endtask

    task automatic launch(logic [15:0] a, logic [15:0] b, string req);
        item_t it;
        @(negedge clk);
        it.a = a; it.b = b; it.req = req; it.t0 = cyc;
        sb.push_back(it);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_div(logic [15:0] a, logic [15:0] b, string req);
        launch(a, b, req);
        wait_empty();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int d0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(quotient == 0, "R1", "quotient in reset", quotient, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(quotient == 0, "R1", "quotient after reset", quotient, 0);

        // R2: distinct patterns
        do_div(16'h4000, 16'h8000, "R2");   // 0.25/0.5
        do_div(16'hC000, 16'hC000, "R2");   // equal operands
        do_div(16'hFFFF, 16'h8000, "R2");   // quotient near 2
        do_div(16'h0001, 16'hFFFF, "R2");   // tiny quotient
        do_div(16'h5555, 16'hAAAB, "R2");

        // R3: zero dividend
        do_div(16'h0000, 16'h1234, "R3");
        do_div(16'h0000, 16'h0001, "R3");

        // R4: every leading-one position
        for (int s = 0; s < 16; s++) begin
            logic [15:0] b;
            b = 16'hFFFF >> s;
            do_div(16'((longint'(b) * 3) / 2 > 16'hFFFF ? 16'hFFFF : (longint'(b) * 3) / 2), b, "R4");
        end
        for (int s = 0; s < 16; s++) begin
            logic [15:0] b;
            b = 16'h8000 >> s;
            do_div(b, b, "R4");
        end

        // R2: pseudo-random operands
        for (int k = 0; k < 60; k++) begin
            logic [15:0] b;
            logic [15:0] a;
            longint lim;
            b = (rnd()[15:0] | 16'h8000) >> (rnd() % 16);
            lim = 2 * longint'(b);
            if (lim > 65536) lim = 65536;
            a = 16'(longint'(rnd()) % lim);
            do_div(a, b, "R2");
        end

        // R8: quotient holds while done is low
        do_div(16'h3000, 16'h9000, "R2");
        repeat (6) @(negedge clk);
        check(quotient == last_q, "R8", "quotient held", quotient, last_q);

        // R7: start while busy is ignored
        d0 = n_done;
        launch(16'h2000, 16'hA000, "R7");
        dividend = 16'hFFFF; divisor = 16'h0003; start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        wait_empty();
        repeat (8) @(negedge clk);
        check(n_done == d0 + 1, "R7", "results for busy start", n_done - d0, 1);

        // R9: reset mid-operation
        d0 = n_done;
        @(negedge clk);
        dividend = 16'h7000; divisor = 16'h9000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check(n_done == d0, "R9", "done after abort", n_done - d0, 0);
        check(quotient == 0, "R9", "quotient after abort", quotient, 0);

        // normal operation resumes
        do_div(16'h6000, 16'hC000, "R2");

        finish_run();
    end
endmodule